// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides where the two ALU operands of the instruction in the execute stage of a five-stage in-order integer pipeline come from. It has three possible sources. The first is the register-file value captured in the decode/execute pipeline register. The second is the result held by the instruction one step ahead, in the memory stage. The third is the result held by the instruction two steps ahead, in the writeback stage. Each operand's source register number is compared with the destination number and register-write flag of both older instructions. The comparison yields one 2-bit select per operand.

The same module also holds the two operand multiplexers, so a pipeline can connect the selected operands straight to the ALU inputs. The whole path is combinational. The selects and operands follow the inputs within the same cycle. There are no registers, so the block has no state machine: "state" here means only the source an operand is taken from in a given cycle. The three source codes are named `SRC_REGFILE` (2'b00), `SRC_WB` (2'b01) and `SRC_MEM` (2'b10). Stalling for load-use cases, the register file and branch resolution are outside this block.

Top module: `fwd_operand_unit`

## Requirements
- R1: When `mem_wr_en` is 1, `mem_rd` is nonzero and `mem_rd` equals `ex_rs_a`, `sel_a` is 2'b10 and `opnd_a` equals `mem_value`.
- R2: When `mem_wr_en` is 1, `mem_rd` is nonzero and `mem_rd` equals `ex_rs_b`, `sel_b` is 2'b10 and `opnd_b` equals `mem_value`.
- R3: When `wb_wr_en` is 1, `wb_rd` is nonzero and equals an operand's source number, and the R1/R2 condition for that operand is false, that operand's select is 2'b01 and the operand equals `wb_value`.
- R4: When the memory-stage and writeback-stage conditions both hold for one operand, the memory stage wins (select 2'b10). For example, three back-to-back writes to the same register deliver the newest value.
- R5: A stage whose write flag is 0 never causes forwarding, whatever its destination number.
- R6: A source register number of 0 always gives select 2'b00 and the register-file value, even when a stage with write flag 1 names destination 0.
- R7: When no forwarding condition holds, the select is 2'b00 and the operand equals its register-file input (`ex_rf_a` or `ex_rf_b`).
- R8: The two operands are resolved independently, so in one cycle A may take the memory-stage value while B takes the writeback-stage value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs_a | input | 5 | First source register number of the execute-stage instruction |
| ex_rs_b | input | 5 | Second source register number of the execute-stage instruction |
| ex_rf_a | input | 32 | Register-file value for the first source |
| ex_rf_b | input | 32 | Register-file value for the second source |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | 5 | Memory-stage destination register number |
| mem_value | input | 32 | Memory-stage result |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| wb_rd | input | 5 | Writeback-stage destination register number |
| wb_value | input | 32 | Writeback-stage result |
| sel_a | output | 2 | Source select for operand A (00 register file, 01 writeback, 10 memory) |
| sel_b | output | 2 | Source select for operand B, same encoding |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
All results are due in the same cycle as the stimulus, with zero register stages on any path. The bench therefore applies each input pattern just after a rising clock edge and samples the selects and operands at the following falling edge, once everything has settled. A near-exhaustive sweep runs over register numbers 0 to 3 for every field and both write-flag values. For each pattern the expected select and operand are worked out arithmetically and compared. Directed patterns then cover the three-write chain on one register and different sources for the two operands.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int REG_IDX_W = 5;
    localparam int DATA_W    = 32;
    localparam int SEL_W     = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } fwd_src_e;
endpackage

// File: rtl/fwd_stage_hit.sv
module fwd_stage_hit #(
    parameter int IDX_W = 5
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] dest,
    input  logic [IDX_W-1:0] src,
    output logic             hit
);
    localparam logic [IDX_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wr_en && (dest != ZERO_REG) && (dest == src);
    end
endmodule

// File: rtl/fwd_src_select.sv
module fwd_src_select
    import fwd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             mem_wr_en,
    input  logic [IDX_W-1:0] mem_rd,
    input  logic             wb_wr_en,
    input  logic [IDX_W-1:0] wb_rd,
    input  logic [IDX_W-1:0] src,
    output fwd_src_e         sel
);
    logic mem_hit;
    logic wb_hit;

    fwd_stage_hit #(.IDX_W(IDX_W)) u_mem_hit (
        .wr_en (mem_wr_en),
        .dest  (mem_rd),
        .src   (src),
        .hit   (mem_hit)
    );

    fwd_stage_hit #(.IDX_W(IDX_W)) u_wb_hit (
        .wr_en (wb_wr_en),
        .dest  (wb_rd),
        .src   (src),
        .hit   (wb_hit)
    );

    // The younger stage is checked first so that its value wins.
    always_comb begin
        if (mem_hit) begin
            sel = SRC_MEM;
        end else if (wb_hit) begin
            sel = SRC_WB;
        end else begin
            sel = SRC_REGFILE;
        end
    end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  fwd_src_e        sel,
    input  logic [DW-1:0]   rf_value,
    input  logic [DW-1:0]   mem_value,
    input  logic [DW-1:0]   wb_value,
    output logic [DW-1:0]   opnd
);
    always_comb begin
        unique case (sel)
            SRC_MEM:     opnd = mem_value;
            SRC_WB:      opnd = wb_value;
            SRC_REGFILE: opnd = rf_value;
            default:     opnd = rf_value;
        endcase
    end
endmodule

// File: rtl/fwd_operand_unit.sv
module fwd_operand_unit
    import fwd_pkg::*;
#(
    parameter int IDX_W = REG_IDX_W,
    parameter int DW    = DATA_W
) (
    input  logic [IDX_W-1:0] ex_rs_a,
    input  logic [IDX_W-1:0] ex_rs_b,
    input  logic [DW-1:0]    ex_rf_a,
    input  logic [DW-1:0]    ex_rf_b,
    input  logic             mem_wr_en,
    input  logic [IDX_W-1:0] mem_rd,
    input  logic [DW-1:0]    mem_value,
    input  logic             wb_wr_en,
    input  logic [IDX_W-1:0] wb_rd,
    input  logic [DW-1:0]    wb_value,
    output logic [SEL_W-1:0] sel_a,
    output logic [SEL_W-1:0] sel_b,
    output logic [DW-1:0]    opnd_a,
    output logic [DW-1:0]    opnd_b
);
    localparam int N_OPND = 2;

    logic [IDX_W-1:0] src_idx [N_OPND];
    logic [DW-1:0]    rf_val  [N_OPND];
    fwd_src_e         src_sel [N_OPND];
    logic [DW-1:0]    opnd    [N_OPND];

    assign src_idx[0] = ex_rs_a;
    assign src_idx[1] = ex_rs_b;
    assign rf_val[0]  = ex_rf_a;
    assign rf_val[1]  = ex_rf_b;

    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
        fwd_src_select #(.IDX_W(IDX_W)) u_sel (
            .mem_wr_en (mem_wr_en),
            .mem_rd    (mem_rd),
            .wb_wr_en  (wb_wr_en),
            .wb_rd     (wb_rd),
            .src       (src_idx[i]),
            .sel       (src_sel[i])
        );

        fwd_operand_mux #(.DW(DW)) u_mux (
            .sel       (src_sel[i]),
            .rf_value  (rf_val[i]),
            .mem_value (mem_value),
            .wb_value  (wb_value),
            .opnd      (opnd[i])
        );
    end

    assign sel_a  = src_sel[0];
    assign sel_b  = src_sel[1];
    assign opnd_a = opnd[0];
    assign opnd_b = opnd[1];
endmodule

// File: rtl/fwd_operand_unit_chk.sv
module fwd_operand_unit_chk #(
    parameter int IDX_W = 5,
    parameter int DW    = 32
) (
    input logic [IDX_W-1:0] ex_rs_a,
    input logic [IDX_W-1:0] ex_rs_b,
    input logic [DW-1:0]    ex_rf_a,
    input logic [DW-1:0]    ex_rf_b,
    input logic             mem_wr_en,
    input logic [IDX_W-1:0] mem_rd,
    input logic [DW-1:0]    mem_value,
    input logic             wb_wr_en,
    input logic [IDX_W-1:0] wb_rd,
    input logic [DW-1:0]    wb_value,
    input logic [1:0]       sel_a,
    input logic [1:0]       sel_b,
    input logic [DW-1:0]    opnd_a,
    input logic [DW-1:0]    opnd_b
);
    always_comb begin
        // R1, R2: a memory-stage select delivers the memory value
        if (sel_a == 2'b10) a_r1_mem_value_a: assert (opnd_a == mem_value && mem_wr_en);
        if (sel_b == 2'b10) a_r2_mem_value_b: assert (opnd_b == mem_value && mem_wr_en);
        // R3: a writeback select delivers the writeback value
        if (sel_a == 2'b01) a_r3_wb_value_a: assert (opnd_a == wb_value);
        if (sel_b == 2'b01) a_r3_wb_value_b: assert (opnd_b == wb_value);
        // R4: writeback never chosen while the memory stage matches
        if (sel_a == 2'b01) a_r4_mem_first_a: assert (!(mem_wr_en && mem_rd == ex_rs_a));
        if (sel_b == 2'b01) a_r4_mem_first_b: assert (!(mem_wr_en && mem_rd == ex_rs_b));
        // R5: writeback forwarding needs its write flag
        if (sel_a == 2'b01 || sel_b == 2'b01) a_r5_wb_flag: assert (wb_wr_en);
        // R6: source zero always reads the register file
        if (ex_rs_a == '0) a_r6_zero_a: assert (sel_a == 2'b00 && opnd_a == ex_rf_a);
        if (ex_rs_b == '0) a_r6_zero_b: assert (sel_b == 2'b00 && opnd_b == ex_rf_b);
        // R7: register-file select passes the register-file value
        if (sel_a == 2'b00) a_r7_rf_a: assert (opnd_a == ex_rf_a);
        if (sel_b == 2'b00) a_r7_rf_b: assert (opnd_b == ex_rf_b);
        a_r8_sel_legal: assert (sel_a != 2'b11 && sel_b != 2'b11);
    end
endmodule

bind fwd_operand_unit fwd_operand_unit_chk #(.IDX_W(IDX_W), .DW(DW)) u_chk (
    .ex_rs_a   (ex_rs_a),
    .ex_rs_b   (ex_rs_b),
    .ex_rf_a   (ex_rf_a),
    .ex_rf_b   (ex_rf_b),
    .mem_wr_en (mem_wr_en),
    .mem_rd    (mem_rd),
    .mem_value (mem_value),
    .wb_wr_en  (wb_wr_en),
    .wb_rd     (wb_rd),
    .wb_value  (wb_value),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b)
);

// File: tb/fwd_operand_unit_test.sv
module fwd_operand_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  ex_rs_a, ex_rs_b, mem_rd, wb_rd;
    logic [31:0] ex_rf_a, ex_rf_b, mem_value, wb_value;
    logic        mem_wr_en, wb_wr_en;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwd_operand_unit uut (
        .ex_rs_a(ex_rs_a), .ex_rs_b(ex_rs_b), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
        .mem_wr_en(mem_wr_en), .mem_rd(mem_rd), .mem_value(mem_value),
        .wb_wr_en(wb_wr_en), .wb_rd(wb_rd), .wb_value(wb_value),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    function automatic logic [1:0] exp_sel(input logic [4:0] src);
        if (mem_wr_en && mem_rd != 0 && mem_rd == src) return 2'b10;
        if (wb_wr_en && wb_rd != 0 && wb_rd == src)    return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] exp_val(input logic [1:0] s, input logic [31:0] rf);
        return (s == 2'b10) ? mem_value : (s == 2'b01) ? wb_value : rf;
    endfunction

    function automatic string tag_of(input logic [1:0] s, input logic [4:0] src, input bit is_b);
        if (src == 0)     return "R6";
        if (s == 2'b10)   return is_b ? "R2" : "R1";
        if (s == 2'b01)   return "R3";
        return "R7";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string force_tag);
        logic [1:0] ea, eb;
        string ta, tb;
        ea = exp_sel(ex_rs_a);
        eb = exp_sel(ex_rs_b);
        ta = (force_tag != "") ? force_tag : tag_of(ea, ex_rs_a, 1'b0);
        tb = (force_tag != "") ? force_tag : tag_of(eb, ex_rs_b, 1'b1);
        check(ta, "sel_a",  {30'd0, sel_a}, {30'd0, ea});
        check(tb, "sel_b",  {30'd0, sel_b}, {30'd0, eb});
        check(ta, "opnd_a", opnd_a, exp_val(ea, ex_rf_a));
        check(tb, "opnd_b", opnd_b, exp_val(eb, ex_rf_b));
    endtask

    task automatic apply(input logic [4:0] ra, input logic [4:0] rb,
                         input logic mwe, input logic [4:0] mrd,
                         input logic wwe, input logic [4:0] wrd);
        @(posedge clk);
        ex_rs_a = ra; ex_rs_b = rb;
        mem_wr_en = mwe; mem_rd = mrd;
        wb_wr_en = wwe; wb_rd = wrd;
        ex_rf_a   = 32'h1100_0000 | {27'd0, ra};
        ex_rf_b   = 32'h2200_0000 | {27'd0, rb};
        mem_value = 32'hA000_0000 | {27'd0, mrd};
        wb_value  = 32'hB000_0000 | {27'd0, wrd};
        @(negedge clk);
    endtask

    initial begin
        ex_rs_a = '0; ex_rs_b = '0; ex_rf_a = '0; ex_rf_b = '0;
        mem_wr_en = 1'b0; mem_rd = '0; mem_value = '0;
        wb_wr_en = 1'b0; wb_rd = '0; wb_value = '0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Quiet state: all selects at register file (R7)
        check("R7", "idle sel_a", {30'd0, sel_a}, 32'd0);
        check("R7", "idle sel_b", {30'd0, sel_b}, 32'd0);

        // Near-exhaustive sweep over register numbers 0..3 (R1, R2, R3, R5, R6, R7)
        for (int mwe = 0; mwe < 2; mwe++)
            for (int mrd = 0; mrd < 4; mrd++)
                for (int wwe = 0; wwe < 2; wwe++)
                    for (int wrd = 0; wrd < 4; wrd++)
                        for (int ra = 0; ra < 4; ra++)
                            for (int rb = 0; rb < 4; rb++) begin
                                apply(5'(ra), 5'(rb), 1'(mwe), 5'(mrd), 1'(wwe), 5'(wrd));
                                check_all("");
                            end

        // R4: chain of three writes to r9; memory stage holds the newest
        apply(5'd9, 5'd9, 1'b1, 5'd9, 1'b1, 5'd9);
        check("R4", "chain sel_a", {30'd0, sel_a}, 32'd2);
        check("R4", "chain opnd_a", opnd_a, mem_value);
        check("R4", "chain opnd_b", opnd_b, mem_value);

        // R5: write flags low, destinations match, no forwarding
        apply(5'd17, 5'd30, 1'b0, 5'd17, 1'b0, 5'd30);
        check_all("R5");

        // R6: destination 0 with write flag high on both stages
        apply(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
        check_all("R6");

        // R8: A from memory stage, B from writeback stage
        apply(5'd31, 5'd12, 1'b1, 5'd31, 1'b1, 5'd12);
        check("R8", "indep sel_a", {30'd0, sel_a}, 32'd2);
        check("R8", "indep sel_b", {30'd0, sel_b}, 32'd1);
        check("R8", "indep opnd_a", opnd_a, mem_value);
        check("R8", "indep opnd_b", opnd_b, wb_value);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule